// File: doc/BRIEF.md
# Three-Wire Serial Master with Split Write/Read Phases

This block is a register-mapped master for a three-wire synchronous serial link made of a clock, a data-out line and a data-in line, plus four active-low select lines. Software places a word in the transmit register. It then sets a write bit count, a read bit count, a target select and a select-enable bit in the control/status word. A transfer first shifts the upper bits of the transmit word out, most significant bit first. It then clocks the requested number of bits in from the target.

A transfer starts in one of two ways. Software can set the start bit in a control write. The block can also start a transfer by itself when the transmit register is written, if the fifth setup register enables this. The end of each phase is reported as a one-cycle pulse. The end of the write phase goes out either on the transmit interrupt or on the transmit DMA request. The end of the read phase goes out on the receive interrupt, or is left to polling. The block also keeps a busy flag and a ready flag. A buffer access sets or clears each flag.

Top module: `uwire_master`

## Requirements
- R1: After reset the control word and all five setup registers read as zero, both status flags are clear, all select lines are high and the serial clock is low.
- R2: Writes to the setup registers at byte offsets 0x08, 0x0C, 0x10, 0x14 and 0x18 keep only the bits in masks 0x003F, 0x0FC0, 0x0003, 0x0001 and 0x000F. Read-back returns the masked value.
- R3: A write to the control/status word at offset 0x04 stores bits [12:0]. Bit 13 is the start bit and reads back as zero. On a read, bit 15 returns the ready flag and bit 14 returns the busy flag.
- R4: A write to the data register at offset 0x00 loads the transmit word and sets busy. The write phase sends the top N bits, where N is control bits [9:5], most significant bit first. At the end of the phase busy clears and one single-cycle transmit-complete pulse is issued.
- R5: The read phase runs after the write phase and clocks in M bits, where M is control bits [4:0]. Each bit enters at the least significant end. At the end of the phase the received word is readable at offset 0x00, ready is set and one single-cycle receive pulse is issued.
- R6: A read of offset 0x00 clears the ready flag.
- R7: A phase whose bit count is zero is skipped. With N = 0, busy stays set. With M = 0, ready stays clear.
- R8: A data-register write starts a transfer only when setup-5 bit 2 is set and either setup-5 bit 3 or control bit 12 is set. Otherwise no serial clock edge appears.
- R9: The select line chosen by control bits [11:10] is driven low only while control bit 12 is set and a transfer is running. The other select lines stay high.
- R10: The serial clock stays high for CLK_DIV system cycles and low for CLK_DIV system cycles. Data out changes on falling edges and data in is sampled on rising edges.
- R11: A start request made while a transfer is running is ignored.
- R12: When setup-5 bit 0 is set, the write-phase completion pulse appears on the transmit DMA request instead of the transmit interrupt. When setup-5 bit 1 is set, the receive interrupt is suppressed.
- R13: A read at an undefined or unaligned offset returns zero. A write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from the address |
| sdi | input | 1 | Serial data from the target |
| sdo | output | 1 | Serial data to the target |
| sclk | output | 1 | Serial clock, idle low |
| csN | output | 4 | Active-low select lines |
| txIrq | output | 1 | Write-phase completion interrupt pulse |
| rxIrq | output | 1 | Read-phase completion interrupt pulse |
| txDmaReq | output | 1 | Write-phase completion DMA request pulse |

## Verification
The bench builds the block with CLK_DIV = 3. This makes the divider an odd count, so a counter compare that is off by one changes the measured half-period. Bit counts of 4, 5, 8 and 12 are used. These cover a write-only transfer, a read-only transfer, mixed transfers and a phase of zero length. A target model in the bench records the data-out bits and returns a known reply word, so the word framing can be checked in both directions.

// File: rtl/uwm_pkg.sv
`timescale 1ns/1ps
package uwm_pkg;
  localparam int DATA_W  = 16;
  localparam int CNT_W   = 5;
  localparam int CS_W    = 2;
  localparam int NUM_CS  = 1 << CS_W;
  localparam int NUM_SET = 5;

  // strobes and levels from the sequencer to the datapath
  typedef struct packed {
    logic loadShift;
    logic shiftTx;
    logic sampleRx;
    logic clearRx;
    logic txDone;
    logic rxDone;
    logic inWrite;
  } uwmStrobe_t;

  function automatic logic [DATA_W-1:0] setupMask(input int idx);
    case (idx)
      0: setupMask = 16'h003F;
      1: setupMask = 16'h0FC0;
      2: setupMask = 16'h0003;
      3: setupMask = 16'h0001;
      default: setupMask = 16'h000F;
    endcase
  endfunction
endpackage

// File: rtl/uwm_ctrl.sv
`timescale 1ns/1ps
module uwm_ctrl
  import uwm_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] wrBits,
  input  logic [CNT_W-1:0] rdBits,
  input  logic [CS_W-1:0]  csIdx,
  input  logic             csCmd,
  output uwmStrobe_t       strobe,
  output logic             sclk,
  output logic [NUM_CS-1:0] csN
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} state_t;
  state_t state;

  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] rdLatch;
  logic [CS_W-1:0]  csIdxLatch;
  logic             cmdLatch;
  logic             sclkReg;

  logic active, edgeNow, accept, lastBit;
  assign active  = (state != ST_IDLE);
  assign edgeNow = active && (divCnt == DIV_W'(CLK_DIV - 1));
  assign accept  = (state == ST_IDLE) && startReq && ((wrBits != '0) || (rdBits != '0));
  assign lastBit = (bitCnt == CNT_W'(1));

  always_comb begin
    strobe = '0;
    strobe.inWrite   = (state == ST_WRITE);
    strobe.loadShift = accept;
    if (accept && wrBits == '0) strobe.clearRx = 1'b1;
    if (state == ST_WRITE && edgeNow && sclkReg) begin
      strobe.shiftTx = 1'b1;
      if (lastBit) begin
        strobe.txDone = 1'b1;
        if (rdLatch != '0) strobe.clearRx = 1'b1;
      end
    end
    if (state == ST_READ && edgeNow && !sclkReg) strobe.sampleRx = 1'b1;
    if (state == ST_READ && edgeNow && sclkReg && lastBit) strobe.rxDone = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      bitCnt     <= '0;
      rdLatch    <= '0;
      csIdxLatch <= '0;
      cmdLatch   <= 1'b0;
      sclkReg    <= 1'b0;
    end else if (state == ST_IDLE) begin
      if (accept) begin
        rdLatch    <= rdBits;
        csIdxLatch <= csIdx;
        cmdLatch   <= csCmd;
        divCnt     <= '0;
        sclkReg    <= 1'b0;
        if (wrBits != '0) begin
          state  <= ST_WRITE;
          bitCnt <= wrBits;
        end else begin
          state  <= ST_READ;
          bitCnt <= rdBits;
        end
      end
    end else if (edgeNow) begin
      divCnt  <= '0;
      sclkReg <= ~sclkReg;
      if (sclkReg) begin
        if (lastBit) begin
          if (state == ST_WRITE && rdLatch != '0) begin
            state  <= ST_READ;
            bitCnt <= rdLatch;
          end else begin
            state <= ST_IDLE;
          end
        end else begin
          bitCnt <= bitCnt - CNT_W'(1);
        end
      end
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  assign sclk = sclkReg;

  for (genvar g = 0; g < NUM_CS; g++) begin : gen_cs
    assign csN[g] = !(active && cmdLatch && (csIdxLatch == CS_W'(g)));
  end

  // R9: at most one select line low at a time
  assert_cs_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));
  // R10: the serial clock holds its level between divider wraps
  assert_sclk_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (active && divCnt != '0) |-> $stable(sclk));
  // R11: a start request during the write phase leaves the bit count alone
  assert_start_ignored_R11: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE && startReq && !edgeNow) |=> $stable(bitCnt));
endmodule

// File: rtl/uwm_datapath.sv
`timescale 1ns/1ps
module uwm_datapath
  import uwm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              sdi,
  output logic              sdo,
  input  uwmStrobe_t        strobe,
  output logic              startReq,
  output logic [CNT_W-1:0]  wrBits,
  output logic [CNT_W-1:0]  rdBits,
  output logic [CS_W-1:0]   csIdx,
  output logic              csCmd,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              txDmaReq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [12:0]       ctrlReg;
  logic [DATA_W-1:0] txBuf, rxBuf, txShift, rxShift;
  logic [DATA_W-1:0] setupReg [NUM_SET];
  logic              busyFlag, readyFlag;

  logic [IDX_W-1:0] wordIdx;
  logic aligned, wrEn, rdEn, dataWr, dataRd, ctrlWr, autoGo;
  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign wrEn    = busSel && busWr && aligned;
  assign rdEn    = busSel && !busWr && aligned;
  assign dataWr  = wrEn && (wordIdx == IDX_W'(0));
  assign dataRd  = rdEn && (wordIdx == IDX_W'(0));
  assign ctrlWr  = wrEn && (wordIdx == IDX_W'(1));
  assign autoGo  = setupReg[4][2] && (setupReg[4][3] || ctrlReg[12]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      txBuf     <= '0;
      rxBuf     <= '0;
      txShift   <= '0;
      rxShift   <= '0;
      busyFlag  <= 1'b0;
      readyFlag <= 1'b0;
      startReq  <= 1'b0;
      txIrq     <= 1'b0;
      rxIrq     <= 1'b0;
      txDmaReq  <= 1'b0;
      for (int i = 0; i < NUM_SET; i++) setupReg[i] <= '0;
    end else begin
      startReq <= (ctrlWr && busWdata[13]) || (dataWr && autoGo);
      if (ctrlWr) ctrlReg <= busWdata[12:0];
      if (dataWr) txBuf <= busWdata;
      for (int i = 0; i < NUM_SET; i++)
        if (wrEn && wordIdx == IDX_W'(i + 2)) setupReg[i] <= busWdata & setupMask(i);

      if (dataWr) busyFlag <= 1'b1;
      else if (strobe.txDone) busyFlag <= 1'b0;

      if (strobe.rxDone) readyFlag <= 1'b1;
      else if (dataRd) readyFlag <= 1'b0;

      if (strobe.loadShift) txShift <= txBuf;
      else if (strobe.shiftTx) txShift <= {txShift[DATA_W-2:0], 1'b0};

      if (strobe.clearRx) rxShift <= '0;
      else if (strobe.sampleRx) rxShift <= {rxShift[DATA_W-2:0], sdi};
      if (strobe.rxDone) rxBuf <= rxShift;

      txIrq    <= strobe.txDone && !setupReg[4][0];
      txDmaReq <= strobe.txDone && setupReg[4][0];
      rxIrq    <= strobe.rxDone && !setupReg[4][1];
    end
  end

  always_comb begin
    busRdata = '0;
    if (aligned) begin
      if (wordIdx == IDX_W'(0)) busRdata = rxBuf;
      else if (wordIdx == IDX_W'(1)) busRdata = {readyFlag, busyFlag, 1'b0, ctrlReg};
      else
        for (int i = 0; i < NUM_SET; i++)
          if (wordIdx == IDX_W'(i + 2)) busRdata = setupReg[i];
    end
  end

  assign sdo    = strobe.inWrite && txShift[DATA_W-1];
  assign wrBits = ctrlReg[9:5];
  assign rdBits = ctrlReg[4:0];
  assign csIdx  = ctrlReg[11:10];
  assign csCmd  = ctrlReg[12];

  // R4: a data write always leaves busy set
  assert_busy_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> busyFlag);
  // R4: completion pulse lasts one cycle
  assert_txirq_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |=> !txIrq);
  // R6: reading received data clears ready unless a new word lands
  assert_ready_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !strobe.rxDone) |=> !readyFlag);
  // R12: write completion goes to exactly one of the two outputs
  assert_irq_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(txIrq && txDmaReq));
endmodule

// File: rtl/uwire_master.sv
`timescale 1ns/1ps
module uwire_master
  import uwm_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  input  logic              sdi,
  output logic              sdo,
  output logic              sclk,
  output logic [3:0]        csN,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              txDmaReq
);
  uwmStrobe_t       strobe;
  logic             startReq, csCmd;
  logic [CNT_W-1:0] wrBits, rdBits;
  logic [CS_W-1:0]  csIdx;

  uwm_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sdi(sdi), .sdo(sdo),
    .strobe(strobe), .startReq(startReq), .wrBits(wrBits), .rdBits(rdBits),
    .csIdx(csIdx), .csCmd(csCmd), .txIrq(txIrq), .rxIrq(rxIrq), .txDmaReq(txDmaReq)
  );

  uwm_ctrl #(.CLK_DIV(CLK_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .wrBits(wrBits), .rdBits(rdBits),
    .csIdx(csIdx), .csCmd(csCmd), .strobe(strobe), .sclk(sclk), .csN(csN)
  );
endmodule

// File: tb/sim_uwire_master.sv
`timescale 1ns/1ps
module sim_uwire_master;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        sdi, sdo, sclk, txIrq, rxIrq, txDmaReq;
  logic [3:0]  csN;

  always #4 clk = ~clk;

  uwire_master #(.CLK_DIV(DIV), .ADDR_W(5)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sdi(sdi), .sdo(sdo), .sclk(sclk),
    .csN(csN), .txIrq(txIrq), .rxIrq(rxIrq), .txDmaReq(txDmaReq)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // target model and monitors
  int          rises = 0, wrN = 0, rdN = 0, hiRun = 0, hiBad = 0;
  int          txIrqCnt = 0, rxIrqCnt = 0, dmaCnt = 0;
  logic [15:0] reply = '0, txCap = '0;
  logic [3:0]  csSeen = '0;

  always @(posedge sclk) begin
    if (rises < wrN) txCap = {txCap[14:0], sdo};
    rises = rises + 1;
  end

  always @* begin
    int idx;
    idx = rises - wrN;
    if (idx >= 0 && idx < rdN) sdi = reply[rdN - 1 - idx];
    else sdi = 1'b0;
  end

  always @(posedge clk) begin
    if (rstN) begin
      if (txIrq) txIrqCnt = txIrqCnt + 1;
      if (rxIrq) rxIrqCnt = rxIrqCnt + 1;
      if (txDmaReq) dmaCnt = dmaCnt + 1;
      csSeen = csSeen | ~csN;
      if (sclk) hiRun = hiRun + 1;
      else if (hiRun != 0) begin
        if (hiRun != DIV) hiBad = hiBad + 1;
        hiRun = 0;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic arm(input int w, input int r, input logic [15:0] rep);
    rises = 0; wrN = w; rdN = r; reply = rep; txCap = '0; csSeen = '0;
    txIrqCnt = 0; rxIrqCnt = 0; dmaCnt = 0; hiBad = 0;
  endtask

  task automatic settle(input int w, input int r);
    repeat ((w + r) * 2 * DIV + 12) @(negedge clk);
  endtask

  task automatic testReset();
    logic [15:0] v;
    busRead(5'h04, v); check("R1 control", v, 16'h0000);
    busRead(5'h08, v); check("R1 setup1", v, 16'h0000);
    busRead(5'h18, v); check("R1 setup5", v, 16'h0000);
    check("R1 csN idle", csN, 4'hF);
    check("R1 sclk idle", sclk, 1'b0);
  endtask

  task automatic testSetupMasks();
    logic [15:0] v;
    logic [15:0] masks [5] = '{16'h003F, 16'h0FC0, 16'h0003, 16'h0001, 16'h000F};
    for (int i = 0; i < 5; i++) begin
      busWrite(5'(8 + 4 * i), 16'hFFFF);
      busRead(5'(8 + 4 * i), v);
      check("R2 setup mask", v, masks[i]);
    end
    for (int i = 0; i < 5; i++) busWrite(5'(8 + 4 * i), 16'h0000);
  endtask

  task automatic testUndefined();
    logic [15:0] v;
    busWrite(5'h1C, 16'hFFFF);
    busWrite(5'h02, 16'hFFFF);
    busRead(5'h1C, v); check("R13 undefined read", v, 16'h0000);
    busRead(5'h02, v); check("R13 unaligned read", v, 16'h0000);
    busRead(5'h04, v); check("R13 status untouched", v, 16'h0000);
    busRead(5'h18, v); check("R13 setup untouched", v, 16'h0000);
  endtask

  task automatic testFullTransfer();
    logic [15:0] v;
    busWrite(5'h00, 16'hA5C3);
    busRead(5'h04, v); check("R4 busy on data write", v, 16'h4000);
    arm(8, 8, 16'h3C96);
    busWrite(5'h04, 16'h3908);
    settle(8, 8);
    check("R4 sent bits", txCap[7:0], 8'hA5);
    check("R4 one tx pulse", txIrqCnt, 1);
    check("R5 one rx pulse", rxIrqCnt, 1);
    check("R9 selected line", csSeen, 4'b0100);
    check("R9 lines released", csN, 4'hF);
    check("R10 edge count", rises, 16);
    check("R10 high width", hiBad, 0);
    busRead(5'h04, v); check("R3 status word", v, 16'h9908);
    busRead(5'h00, v); check("R5 received word", v, 16'h0096);
    busRead(5'h04, v); check("R6 ready cleared", v, 16'h1908);
  endtask

  task automatic testWriteOnly();
    logic [15:0] v;
    busWrite(5'h00, 16'h9ABC);
    arm(12, 0, 16'h0000);
    busWrite(5'h04, 16'h2180);
    settle(12, 0);
    check("R4 twelve bits", txCap[11:0], 12'h9AB);
    check("R9 no select without cmd", csSeen, 4'b0000);
    check("R7 no rx pulse", rxIrqCnt, 0);
    busRead(5'h04, v); check("R7 ready stays clear", v, 16'h0180);
  endtask

  task automatic testReadOnly();
    logic [15:0] v;
    arm(0, 5, 16'h0013);
    busWrite(5'h00, 16'h1234);
    repeat (20) @(negedge clk);
    check("R8 no auto start", rises, 0);
    busWrite(5'h04, 16'h2005);
    settle(0, 5);
    check("R7 no tx pulse", txIrqCnt, 0);
    busRead(5'h04, v); check("R7 busy stays set", v, 16'hC005);
    busRead(5'h00, v); check("R5 five bits", v, 16'h0013);
  endtask

  task automatic testAutoStart();
    busWrite(5'h18, 16'h0004);
    busWrite(5'h04, 16'h1480);
    repeat (10) @(negedge clk);
    arm(4, 0, 16'h0000);
    busWrite(5'h00, 16'hF000);
    settle(4, 0);
    check("R8 auto with cmd", txCap[3:0], 4'hF);
    check("R9 line one", csSeen, 4'b0010);
    busWrite(5'h18, 16'h000C);
    busWrite(5'h04, 16'h0080);
    arm(4, 0, 16'h0000);
    busWrite(5'h00, 16'h6000);
    settle(4, 0);
    check("R8 auto with toggle", txCap[3:0], 4'h6);
    check("R8 four edges", rises, 4);
  endtask

  task automatic testModes();
    logic [15:0] v;
    busWrite(5'h18, 16'h0003);
    busWrite(5'h00, 16'h5000);
    arm(4, 4, 16'h000A);
    busWrite(5'h04, 16'h2084);
    settle(4, 4);
    check("R12 dma request", dmaCnt, 1);
    check("R12 no tx irq", txIrqCnt, 0);
    check("R12 no rx irq", rxIrqCnt, 0);
    busRead(5'h04, v); check("R12 ready still set", v[15], 1'b1);
    busRead(5'h00, v); check("R12 word", v, 16'h000A);
    busWrite(5'h18, 16'h0000);
  endtask

  task automatic testIgnoreStart();
    busWrite(5'h00, 16'hC300);
    arm(8, 0, 16'h0000);
    busWrite(5'h04, 16'h2100);
    repeat (5) @(negedge clk);
    busWrite(5'h04, 16'h2063);
    settle(8, 3);
    check("R11 edge count", rises, 8);
    check("R11 sent bits", txCap[7:0], 8'hC3);
    check("R11 no rx pulse", rxIrqCnt, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testSetupMasks();
    testUndefined();
    testFullTransfer();
    testWriteOnly();
    testReadOnly();
    testAutoStart();
    testModes();
    testIgnoreStart();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule